// File: doc/BRIEF.md
# Dual-Clock Read/Write Memory with Parity Lanes

This block is a word-addressed storage array with two symmetric access ports. Each port runs on its own clock and can read or write on any enabled edge. The clocks may be unrelated in frequency and phase. Every stored word holds a data field and a set of parity bits, one parity bit for each byte of data. The parity bits travel with the data exactly as supplied. The block neither computes nor checks them; a neighbour does that.

Each port registers its read result. A synchronous active-low clear on each port forces that port's output register to a fixed value and leaves the stored contents unchanged. The array can be preloaded through a parameter image, so a design can start with a lookup table or seed values already in place.

Inside, every port owns a private copy of the array and a private array of freshness flags. Each flag array tells which copy holds the newer value for an address. As a result, every storage element has exactly one writer and one clock.

Top module: `tdp_parity_ram`

## Requirements
- R1: On a rising edge of a port's clock with its enable high and its clear high, the port's output register loads the word at that port's address. The output shows the word after that one edge, as {parity, data}: parity in the upper PAR_W bits, data in the lower DATA_W bits.
- R2: On an enabled edge with write enable high, the port stores its data and parity inputs at its address unchanged. Parity bit k belongs to data bits 8k+7 down to 8k and is never computed.
- R3: On a write edge, the port's output register loads the contents the location held before the write (read-before-write).
- R4: A low clear on a port sets that port's output register to RST_VAL (default all zero) on its next clock edge, whatever its enable is. The stored contents do not change.
- R5: With a port's enable low, its output register holds its value and nothing is written, even if write enable is high.
- R6: A word written through one port is returned by the other port on any enabled read after the write edge.
- R7: After configuration, word i holds INIT_IMAGE bits [i*WORD_W +: WORD_W], in the same {parity, data} layout.
- R8: When clear is low and enable is high on the same edge, the clear wins and the output shows RST_VAL.
- R9: The two ports operate concurrently on unrelated clocks without disturbing each other's accesses to different addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clr_a_n | input | 1 | Port A synchronous active-low output clear |
| en_a | input | 1 | Port A access enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dinp_a | input | DATA_W/8 | Port A write parity, one bit per byte |
| dout_a | output | DATA_W | Port A registered read data |
| doutp_a | output | DATA_W/8 | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| clr_b_n | input | 1 | Port B synchronous active-low output clear |
| en_b | input | 1 | Port B access enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dinp_b | input | DATA_W/8 | Port B write parity, one bit per byte |
| dout_b | output | DATA_W | Port B registered read data |
| doutp_b | output | DATA_W/8 | Port B registered read parity |

## Verification
The assertions check three things on every edge of each port clock:
- the clear drives the output to its reset value;
- a disabled port keeps its output;
- an enabled port's output equals the word its address selected at that edge.

What the assertions cannot show is whether the word selected was the right one. That covers the preload image, read-before-write, a value crossing from one port to the other, parity lanes kept intact, and a clear that leaves the stored contents alone. Only the bench's scenarios can show these, with both clocks running at unrelated periods and both ports issuing traffic together.

// File: rtl/tdp_pkg.sv
// Shared helpers for the dual-clock parity memory.
// Assumes the data width is a whole number of bytes.
package tdp_pkg;
    // Number of parity lanes: one per data byte.
    function automatic int par_lanes(input int data_w);
        return data_w / 8;
    endfunction

    // Which private copy of the array holds the newest word.
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } src_e;
endpackage

// File: rtl/tdp_bank.sv
// One private copy of the storage array, written by a single port.
// Assumes writes come from one clock only; two asynchronous read taps.
module tdp_bank #(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 18,
    parameter logic [WORD_W*(2**ADDR_W)-1:0] INIT_IMAGE = '0
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr0,
    output logic [WORD_W-1:0] rdata0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic [WORD_W-1:0] rdata1
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Preload every word from the parameter image.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT_IMAGE[i*WORD_W +: WORD_W];
        end
    end

    // Store one word per enabled write edge.
    always_ff @(posedge clk) begin
        if (wr) begin
            mem[waddr] <= wdata;
        end
    end

    // Read taps, one per port.
    assign rdata0 = mem[raddr0];
    assign rdata1 = mem[raddr1];
endmodule

// File: rtl/tdp_flags.sv
// Per-port freshness flags. Both copies agree at start.
// A write through the non-inverting copy makes the flags equal, which
// marks copy A as newest. A write through the inverting copy makes them
// differ, which marks copy B as newest.
// Assumes the other port's flag at the write address is supplied.
module tdp_flags #(
    parameter int ADDR_W = 6,
    parameter bit INVERT = 1'b0
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              other_flag,
    input  logic [ADDR_W-1:0] raddr0,
    output logic              flag0,
    input  logic [ADDR_W-1:0] raddr1,
    output logic              flag1
);
    localparam int DEPTH = 2 ** ADDR_W;

    logic flags [DEPTH];
    logic flag_next;

    // All flags start equal, so copy A is taken as newest.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            flags[i] = 1'b0;
        end
    end

    // The parameter picks whether a write copies or inverts the other flag.
    generate
        if (INVERT) begin : g_inv
            assign flag_next = ~other_flag;
        end else begin : g_copy
            assign flag_next = other_flag;
        end
    endgenerate

    // Record which copy was written last.
    always_ff @(posedge clk) begin
        if (wr) begin
            flags[waddr] <= flag_next;
        end
    end

    assign flag0 = flags[raddr0];
    assign flag1 = flags[raddr1];
endmodule

// File: rtl/tdp_out_reg.sv
// Registered read output of one port with a synchronous active-low clear.
// The clear acts whatever the enable is and wins over a read.
module tdp_out_reg #(
    parameter int WORD_W = 18,
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              en,
    input  logic              clr_n,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] q
);
    // Clear, load on enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= RST_VAL;
        end else if (en) begin
            q <= rd_word;
        end
    end
endmodule

// File: rtl/tdp_parity_ram.sv
// Two-port, two-clock memory storing one parity bit per data byte.
// Each port keeps its own copy of the array. Freshness flags choose the
// copy holding the newest word, so every storage element has one writer.
// Assumes DATA_W is a multiple of 8. Two writes to one address in
// overlapping cycles leave that word undefined.
module tdp_parity_ram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter logic [(DATA_W+DATA_W/8)*(2**ADDR_W)-1:0] INIT_IMAGE = '0,
    parameter logic [(DATA_W+DATA_W/8)-1:0] RST_VAL = '0
) (
    input  logic                    clk_a,
    input  logic                    clr_a_n,
    input  logic                    en_a,
    input  logic                    we_a,
    input  logic [ADDR_W-1:0]       addr_a,
    input  logic [DATA_W-1:0]       din_a,
    input  logic [DATA_W/8-1:0]     dinp_a,
    output logic [DATA_W-1:0]       dout_a,
    output logic [DATA_W/8-1:0]     doutp_a,
    input  logic                    clk_b,
    input  logic                    clr_b_n,
    input  logic                    en_b,
    input  logic                    we_b,
    input  logic [ADDR_W-1:0]       addr_b,
    input  logic [DATA_W-1:0]       din_b,
    input  logic [DATA_W/8-1:0]     dinp_b,
    output logic [DATA_W-1:0]       dout_b,
    output logic [DATA_W/8-1:0]     doutp_b
);
    import tdp_pkg::*;

    localparam int PAR_W  = par_lanes(DATA_W);
    localparam int WORD_W = DATA_W + PAR_W;

    logic              wr_a, wr_b;
    logic [WORD_W-1:0] wword_a, wword_b;
    logic [WORD_W-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
    logic              fa_at_a, fa_at_b, fb_at_a, fb_at_b;
    src_e              src_a, src_b;
    logic [WORD_W-1:0] rdw_a, rdw_b;
    logic [WORD_W-1:0] q_a, q_b;

    // Write strobes and packed {parity, data} words.
    assign wr_a    = en_a & we_a;
    assign wr_b    = en_b & we_b;
    assign wword_a = {dinp_a, din_a};
    assign wword_b = {dinp_b, din_b};

    tdp_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .INIT_IMAGE(INIT_IMAGE)) u_bank_a (
        .clk(clk_a), .wr(wr_a), .waddr(addr_a), .wdata(wword_a),
        .raddr0(addr_a), .rdata0(bank_a_at_a),
        .raddr1(addr_b), .rdata1(bank_a_at_b)
    );

    tdp_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .INIT_IMAGE(INIT_IMAGE)) u_bank_b (
        .clk(clk_b), .wr(wr_b), .waddr(addr_b), .wdata(wword_b),
        .raddr0(addr_a), .rdata0(bank_b_at_a),
        .raddr1(addr_b), .rdata1(bank_b_at_b)
    );

    tdp_flags #(.ADDR_W(ADDR_W), .INVERT(1'b0)) u_flags_a (
        .clk(clk_a), .wr(wr_a), .waddr(addr_a), .other_flag(fb_at_a),
        .raddr0(addr_a), .flag0(fa_at_a),
        .raddr1(addr_b), .flag1(fa_at_b)
    );

    tdp_flags #(.ADDR_W(ADDR_W), .INVERT(1'b1)) u_flags_b (
        .clk(clk_b), .wr(wr_b), .waddr(addr_b), .other_flag(fa_at_b),
        .raddr0(addr_a), .flag0(fb_at_a),
        .raddr1(addr_b), .flag1(fb_at_b)
    );

    // Pick the newest copy for each port's address.
    always_comb begin
        src_a = (fa_at_a == fb_at_a) ? SRC_A : SRC_B;
        src_b = (fa_at_b == fb_at_b) ? SRC_A : SRC_B;
        rdw_a = (src_a == SRC_A) ? bank_a_at_a : bank_b_at_a;
        rdw_b = (src_b == SRC_A) ? bank_a_at_b : bank_b_at_b;
    end

    tdp_out_reg #(.WORD_W(WORD_W), .RST_VAL(RST_VAL)) u_out_a (
        .clk(clk_a), .en(en_a), .clr_n(clr_a_n), .rd_word(rdw_a), .q(q_a)
    );

    tdp_out_reg #(.WORD_W(WORD_W), .RST_VAL(RST_VAL)) u_out_b (
        .clk(clk_b), .en(en_b), .clr_n(clr_b_n), .rd_word(rdw_b), .q(q_b)
    );

    // Split the output words back into data and parity.
    assign {doutp_a, dout_a} = q_a;
    assign {doutp_b, dout_b} = q_b;
endmodule

// File: rtl/tdp_parity_ram_chk.sv
// Per-edge checks on both ports of the dual-clock parity memory.
// Assumes nothing before the first edge of each clock.
module tdp_parity_ram_chk #(
    parameter int WORD_W = 18,
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input logic              clk_a,
    input logic              clr_a_n,
    input logic              en_a,
    input logic [WORD_W-1:0] out_a,
    input logic [WORD_W-1:0] rdw_a,
    input logic              clk_b,
    input logic              clr_b_n,
    input logic              en_b,
    input logic [WORD_W-1:0] out_b,
    input logic [WORD_W-1:0] rdw_b
);
    logic seen_a = 1'b0;
    logic seen_b = 1'b0;

    // Mark that each clock has produced an edge.
    always_ff @(posedge clk_a) seen_a <= 1'b1;
    always_ff @(posedge clk_b) seen_b <= 1'b1;

    a_r4_clear_a: assert property (@(posedge clk_a) disable iff (!seen_a)
        !clr_a_n |=> (out_a == RST_VAL));
    a_r4_clear_b: assert property (@(posedge clk_b) disable iff (!seen_b)
        !clr_b_n |=> (out_b == RST_VAL));
    a_r5_hold_a: assert property (@(posedge clk_a) disable iff (!seen_a)
        (clr_a_n && !en_a) |=> $stable(out_a));
    a_r5_hold_b: assert property (@(posedge clk_b) disable iff (!seen_b)
        (clr_b_n && !en_b) |=> $stable(out_b));
    a_r1_read_a: assert property (@(posedge clk_a) disable iff (!seen_a)
        (clr_a_n && en_a) |=> (out_a == $past(rdw_a)));
    a_r1_read_b: assert property (@(posedge clk_b) disable iff (!seen_b)
        (clr_b_n && en_b) |=> (out_b == $past(rdw_b)));
endmodule

bind tdp_parity_ram tdp_parity_ram_chk #(.WORD_W(WORD_W), .RST_VAL(RST_VAL)) u_chk (
    .clk_a(clk_a), .clr_a_n(clr_a_n), .en_a(en_a), .out_a(q_a), .rdw_a(rdw_a),
    .clk_b(clk_b), .clr_b_n(clr_b_n), .en_b(en_b), .out_b(q_b), .rdw_b(rdw_b)
);

// File: tb/tdp_parity_ram_bench.sv
// Bench: a table of single-port accesses, then directed clear, hold and
// concurrent two-clock traffic tests.
module tdp_parity_ram_bench;
    localparam int DATA_W = 16;
    localparam int PAR_W  = 2;
    localparam int WORD_W = 18;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 64;

    // Preload rule: word i = {i[1:0], 16'hC000 | i}.
    function automatic logic [WORD_W-1:0] init_word(input int i);
        return {PAR_W'(i), (16'hC000 | 16'(i))};
    endfunction

    function automatic logic [WORD_W*DEPTH-1:0] build_image();
        logic [WORD_W*DEPTH-1:0] img;
        img = '0;
        for (int i = 0; i < DEPTH; i++) img[i*WORD_W +: WORD_W] = init_word(i);
        return img;
    endfunction

    localparam logic [WORD_W*DEPTH-1:0] IMAGE = build_image();

    // Entry: {port(0=A,1=B), we, addr[5:0], write word[17:0], expected out[17:0]}
    localparam int NVEC = 11;
    localparam logic [43:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 6'd5,  18'h00000, 18'h1C005},
        {1'b1, 1'b0, 6'd5,  18'h00000, 18'h1C005},
        {1'b0, 1'b1, 6'd10, 18'h2BEEF, 18'h2C00A},
        {1'b1, 1'b0, 6'd10, 18'h00000, 18'h2BEEF},
        {1'b1, 1'b1, 6'd10, 18'h11234, 18'h2BEEF},
        {1'b0, 1'b0, 6'd10, 18'h00000, 18'h11234},
        {1'b1, 1'b1, 6'd63, 18'h3FFFF, 18'h3C03F},
        {1'b0, 1'b0, 6'd63, 18'h00000, 18'h3FFFF},
        {1'b0, 1'b1, 6'd0,  18'h00000, 18'h0C000},
        {1'b1, 1'b0, 6'd0,  18'h00000, 18'h00000},
        {1'b0, 1'b0, 6'd1,  18'h00000, 18'h1C001}
    };

    logic clk_a = 1'b0, clk_b = 1'b0;
    logic clr_a_n, en_a, we_a, clr_b_n, en_b, we_b;
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [DATA_W-1:0] din_a, din_b, dout_a, dout_b;
    logic [PAR_W-1:0]  dinp_a, dinp_b, doutp_a, doutp_b;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk_a = ~clk_a;   // 100 MHz
    always #7 clk_b = ~clk_b;   // unrelated second clock

    tdp_parity_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .INIT_IMAGE(IMAGE)) u_tdp_parity_ram (
        .clk_a(clk_a), .clr_a_n(clr_a_n), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dinp_a(dinp_a), .dout_a(dout_a), .doutp_a(doutp_a),
        .clk_b(clk_b), .clr_b_n(clr_b_n), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dinp_b(dinp_b), .dout_b(dout_b), .doutp_b(doutp_b)
    );

    task automatic check(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access on port A: drive at a falling edge, one rising edge, back to idle.
    task automatic op_a(input logic clr_n, input logic en, input logic we,
                        input logic [ADDR_W-1:0] addr, input logic [WORD_W-1:0] w);
        @(negedge clk_a);
        clr_a_n = clr_n; en_a = en; we_a = we; addr_a = addr; {dinp_a, din_a} = w;
        @(posedge clk_a);
        @(negedge clk_a);
        clr_a_n = 1'b1; en_a = 1'b0; we_a = 1'b0;
    endtask

    task automatic op_b(input logic clr_n, input logic en, input logic we,
                        input logic [ADDR_W-1:0] addr, input logic [WORD_W-1:0] w);
        @(negedge clk_b);
        clr_b_n = clr_n; en_b = en; we_b = we; addr_b = addr; {dinp_b, din_b} = w;
        @(posedge clk_b);
        @(negedge clk_b);
        clr_b_n = 1'b1; en_b = 1'b0; we_b = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        clr_a_n = 1'b0; en_a = 1'b0; we_a = 1'b0; addr_a = '0; din_a = '0; dinp_a = '0;
        clr_b_n = 1'b0; en_b = 1'b0; we_b = 1'b0; addr_b = '0; din_b = '0; dinp_b = '0;
        // R4: reset state after the first clear edge on each port.
        @(negedge clk_a); check("R4 reset state port A", {doutp_a, dout_a}, '0);
        @(negedge clk_b); check("R4 reset state port B", {doutp_b, dout_b}, '0);
        clr_a_n = 1'b1; clr_b_n = 1'b1;

        // R1 R2 R3 R6 R7: table walk.
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            v = VECS[i];
            if (v[43] == 1'b0) begin
                op_a(1'b1, 1'b1, v[42], v[41:36], v[35:18]);
                check($sformatf("R1 R2 R3 R6 R7 table %0d port A", i), {doutp_a, dout_a}, v[17:0]);
            end else begin
                op_b(1'b1, 1'b1, v[42], v[41:36], v[35:18]);
                check($sformatf("R1 R2 R3 R6 R7 table %0d port B", i), {doutp_b, dout_b}, v[17:0]);
            end
        end

        // R4: clearing leaves the stored word intact.
        op_a(1'b1, 1'b1, 1'b0, 6'd6, '0);
        check("R7 read addr 6", {doutp_a, dout_a}, 18'h2C006);
        op_a(1'b0, 1'b0, 1'b0, 6'd6, '0);
        check("R4 clear with enable low", {doutp_a, dout_a}, '0);
        op_a(1'b1, 1'b1, 1'b0, 6'd6, '0);
        check("R4 contents kept after clear", {doutp_a, dout_a}, 18'h2C006);

        // R8: clear beats a read on the same edge.
        op_b(1'b1, 1'b1, 1'b0, 6'd7, '0);
        check("R7 read addr 7 port B", {doutp_b, dout_b}, 18'h3C007);
        op_b(1'b0, 1'b1, 1'b0, 6'd7, '0);
        check("R8 clear over read", {doutp_b, dout_b}, '0);

        // R5: enable low holds the output and blocks the write.
        op_a(1'b1, 1'b1, 1'b0, 6'd6, '0);
        op_a(1'b1, 1'b0, 1'b1, 6'd6, 18'h3AAAA);
        check("R5 output held", {doutp_a, dout_a}, 18'h2C006);
        op_b(1'b1, 1'b1, 1'b0, 6'd6, '0);
        check("R5 no write while disabled", {doutp_b, dout_b}, 18'h2C006);

        // R9: both ports write at once on their own clocks.
        fork
            for (int k = 0; k < 8; k++) op_a(1'b1, 1'b1, 1'b1, 6'(20 + k), {PAR_W'(k), 16'hA000 + 16'(k)});
            for (int k = 0; k < 8; k++) op_b(1'b1, 1'b1, 1'b1, 6'(40 + k), {PAR_W'(k), 16'h5000 + 16'(k)});
        join
        fork
            for (int k = 0; k < 8; k++) begin
                op_a(1'b1, 1'b1, 1'b0, 6'(40 + k), '0);
                check("R9 R6 port A sees port B writes", {doutp_a, dout_a}, {PAR_W'(k), 16'h5000 + 16'(k)});
            end
            for (int k = 0; k < 8; k++) begin
                op_b(1'b1, 1'b1, 1'b0, 6'(20 + k), '0);
                check("R9 R6 port B sees port A writes", {doutp_b, dout_b}, {PAR_W'(k), 16'hA000 + 16'(k)});
            end
        join

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule